// File: doc/BRIEF.md
# Guarded Indexed Halfword Load Unit

This block is the data-memory load path for a single load operation. It forms a byte address as the 32-bit sum of a base operand and an index operand, reads two consecutive bytes from a synchronous byte-addressed memory, and puts them in the order chosen by a runtime byte-order bit. It then widens the 16-bit value to 32 bits with zeros and hands the result, with its destination register tag, to a writeback port exactly three cycles after issue.

Each operation carries a predicate. Only bit 0 of the predicate operand matters. A false predicate makes the operation vanish: the unit sends no memory request and produces no writeback. The unit takes one new operation every cycle. An odd address never faults. An address inside a parameterised I/O window is not sent to memory, because only word accesses are defined there. Both of these cases still complete with a writeback.

Top module: `hw_ld16_unit`

## Requirements
- R1: After synchronous reset, `mem_rd_en` and `wb_vld` are low and stay low until an operation with a true predicate is issued.
- R2: The effective address is `iss_base + iss_index` modulo 2^32. It appears on `mem_rd_addr` with `mem_rd_en` high in the cycle after issue. Example: 0xFFFFFFF0 + 0x20 reads from 0x10.
- R3: When `iss_little` is 0, the byte at the effective address becomes result bits 15:8 and the byte at address+1 becomes bits 7:0. `mem_rd_data[7:0]` holds the byte at the address and `mem_rd_data[15:8]` holds the byte at address+1, returned one cycle after `mem_rd_en`.
- R4: When `iss_little` is 1, the byte at the effective address becomes result bits 7:0 and the byte at address+1 becomes bits 15:8.
- R5: `wb_data[31:16]` is zero on every writeback.
- R6: Only `iss_guard[0]` is examined. When it is 0 (for example a predicate of 0xFFFFFFFE), the operation causes no `mem_rd_en` and no `wb_vld`. When it is 1 (for example 0x3), the result is written back.
- R7: For an operation issued in cycle c with a true predicate, `wb_vld`, `wb_dest` and `wb_data` are presented together in cycle c+3, with `wb_dest` equal to the issued `iss_dest`.
- R8: Operations issued in consecutive cycles each produce their own writeback in consecutive cycles, in issue order.
- R9: An odd effective address raises no error. The operation still completes with `wb_vld` and its tag in cycle c+3; the data value is unspecified.
- R10: An effective address in [MMIO_BASE, MMIO_BASE+MMIO_SIZE) issues no memory read. The operation still writes back in cycle c+3, with data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_vld | input | 1 | An operation is issued this cycle |
| iss_base | input | 32 | Base operand |
| iss_index | input | 32 | Index operand |
| iss_guard | input | 32 | Predicate operand; only bit 0 is used |
| iss_little | input | 1 | Byte order: 0 big-endian, 1 little-endian |
| iss_dest | input | TAG_W | Destination register tag |
| mem_rd_en | output | 1 | Two-byte read request |
| mem_rd_addr | output | 32 | Byte address of the read |
| mem_rd_data | input | 16 | Returned bytes: [7:0] at address, [15:8] at address+1 |
| wb_vld | output | 1 | Writeback strobe |
| wb_dest | output | TAG_W | Writeback register tag |
| wb_data | output | 32 | Zero-extended halfword |

## Verification
The read request for an operation driven in cycle c is due in cycle c+1, and its writeback is due in cycle c+3. The driver stamps every expected item with its due cycle from a free-running cycle count. The monitor samples at the falling edge and compares both the cycle and the contents against the head of its queue. If a request or writeback arrives with no queued item, the monitor reports it. If a queued item's due cycle passes without arrival, the monitor also reports it. This is how a suppressed operation (false predicate, or memory read inside the I/O window) is shown to leave the ports untouched.

// File: rtl/hlu_pkg.sv
package hlu_pkg;

  typedef enum logic {
    ORD_BIG    = 1'b0,
    ORD_LITTLE = 1'b1
  } byte_order_e;

  localparam int BYTE_W = 8;
  localparam int HALF_W = 2 * BYTE_W;
  localparam int WORD_W = 4 * BYTE_W;

  // pair[7:0] is the byte at the effective address, pair[15:8] the next one
  function automatic logic [WORD_W-1:0] order_zext(input logic [HALF_W-1:0] pair,
                                                   input byte_order_e ord);
    logic [HALF_W-1:0] half;
    if (ord == ORD_BIG) half = {pair[BYTE_W-1:0], pair[HALF_W-1:BYTE_W]};
    else                half = pair;
    return {{(WORD_W-HALF_W){1'b0}}, half};
  endfunction

endpackage

// File: rtl/hlu_addr_stage.sv
module hlu_addr_stage #(
  parameter int          TAG_W     = 5,
  parameter logic [31:0] MMIO_BASE = 32'h0001_0000,
  parameter logic [31:0] MMIO_SIZE = 32'h0000_1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             iss_vld,
  input  logic [31:0]      iss_base,
  input  logic [31:0]      iss_index,
  input  logic [31:0]      iss_guard,
  input  logic             iss_little,
  input  logic [TAG_W-1:0] iss_dest,
  output logic             s1_vld,
  output logic             s1_mmio,
  output logic             s1_little,
  output logic [TAG_W-1:0] s1_dest,
  output logic             rd_en,
  output logic [31:0]      rd_addr
);

  logic [31:0] ea;
  logic [31:0] win_off;
  logic        in_win;
  logic        take;

  always_comb begin
    ea      = iss_base + iss_index;
    win_off = ea - MMIO_BASE;
    in_win  = (win_off < MMIO_SIZE);
    take    = iss_vld && iss_guard[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld    <= 1'b0;
      s1_mmio   <= 1'b0;
      s1_little <= 1'b0;
      s1_dest   <= '0;
      rd_en     <= 1'b0;
      rd_addr   <= '0;
    end else begin
      s1_vld <= take;
      rd_en  <= take && !in_win;
      if (take) begin
        s1_mmio   <= in_win;
        s1_little <= iss_little;
        s1_dest   <= iss_dest;
        rd_addr   <= ea;
      end
    end
  end

  // R6
  guard_false_no_read_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_vld && !iss_guard[0]) |=> !rd_en);

  // R10
  mmio_no_read_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_vld && in_win) |=> !rd_en);

endmodule

// File: rtl/hlu_delay.sv
module hlu_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  generate
    if (DEPTH == 0) begin : g_pass
      assign dout = din;
    end else begin : g_chain
      logic [W-1:0] stage [DEPTH];
      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk) begin
          if (rst) stage[i] <= '0;
          else if (i == 0) stage[i] <= din;
          else stage[i] <= stage[(i == 0) ? 0 : i-1];
        end
      end
      assign dout = stage[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/hlu_align_stage.sv
module hlu_align_stage
  import hlu_pkg::*;
#(
  parameter int TAG_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s2_vld,
  input  logic              s2_mmio,
  input  logic              s2_little,
  input  logic [TAG_W-1:0]  s2_dest,
  input  logic [HALF_W-1:0] rd_data,
  output logic              wb_vld,
  output logic [TAG_W-1:0]  wb_dest,
  output logic [WORD_W-1:0] wb_data
);

  logic [WORD_W-1:0] shaped;

  always_comb begin
    if (s2_mmio) shaped = '0;
    else         shaped = order_zext(rd_data, byte_order_e'(s2_little));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_vld  <= 1'b0;
      wb_dest <= '0;
      wb_data <= '0;
    end else begin
      wb_vld <= s2_vld;
      if (s2_vld) begin
        wb_dest <= s2_dest;
        wb_data <= shaped;
      end
    end
  end

  // R5
  zext_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wb_vld |-> (wb_data[WORD_W-1:HALF_W] == '0));

endmodule

// File: rtl/hw_ld16_unit.sv
module hw_ld16_unit #(
  parameter int          TAG_W     = 5,
  parameter logic [31:0] MMIO_BASE = 32'h0001_0000,
  parameter logic [31:0] MMIO_SIZE = 32'h0000_1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             iss_vld,
  input  logic [31:0]      iss_base,
  input  logic [31:0]      iss_index,
  input  logic [31:0]      iss_guard,
  input  logic             iss_little,
  input  logic [TAG_W-1:0] iss_dest,
  output logic             mem_rd_en,
  output logic [31:0]      mem_rd_addr,
  input  logic [15:0]      mem_rd_data,
  output logic             wb_vld,
  output logic [TAG_W-1:0] wb_dest,
  output logic [31:0]      wb_data
);

  localparam int CTL_W = TAG_W + 3;

  logic             s1_vld, s1_mmio, s1_little;
  logic [TAG_W-1:0] s1_dest;
  logic             s2_vld, s2_mmio, s2_little;
  logic [TAG_W-1:0] s2_dest;
  logic [CTL_W-1:0] s1_ctl, s2_ctl;

  hlu_addr_stage #(
    .TAG_W(TAG_W), .MMIO_BASE(MMIO_BASE), .MMIO_SIZE(MMIO_SIZE)
  ) addr_i (
    .clk(clk), .rst(rst),
    .iss_vld(iss_vld), .iss_base(iss_base), .iss_index(iss_index),
    .iss_guard(iss_guard), .iss_little(iss_little), .iss_dest(iss_dest),
    .s1_vld(s1_vld), .s1_mmio(s1_mmio), .s1_little(s1_little), .s1_dest(s1_dest),
    .rd_en(mem_rd_en), .rd_addr(mem_rd_addr)
  );

  assign s1_ctl = {s1_vld, s1_mmio, s1_little, s1_dest};

  hlu_delay #(.W(CTL_W), .DEPTH(1)) ctl_dly_i (
    .clk(clk), .rst(rst), .din(s1_ctl), .dout(s2_ctl)
  );

  assign {s2_vld, s2_mmio, s2_little, s2_dest} = s2_ctl;

  hlu_align_stage #(.TAG_W(TAG_W)) align_i (
    .clk(clk), .rst(rst),
    .s2_vld(s2_vld), .s2_mmio(s2_mmio), .s2_little(s2_little), .s2_dest(s2_dest),
    .rd_data(mem_rd_data),
    .wb_vld(wb_vld), .wb_dest(wb_dest), .wb_data(wb_data)
  );

  // R2
  rd_addr_sum_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> (mem_rd_addr == $past(iss_base + iss_index)));

  // R7
  wb_follows_issue_chk: assert property (@(posedge clk) disable iff (rst)
    wb_vld |-> $past(iss_vld && iss_guard[0], 3));

  // R7
  wb_tag_chk: assert property (@(posedge clk) disable iff (rst)
    wb_vld |-> (wb_dest == $past(iss_dest, 3)));

endmodule

// File: tb/hw_ld16_unit_tb_top.sv
module hw_ld16_unit_tb_top;

  localparam int TAG_W = 5;
  localparam int MEM_N = 4096;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             iss_vld = 1'b0;
  logic [31:0]      iss_base = '0, iss_index = '0, iss_guard = '0;
  logic             iss_little = 1'b0;
  logic [TAG_W-1:0] iss_dest = '0;
  logic             mem_rd_en;
  logic [31:0]      mem_rd_addr;
  logic [15:0]      mem_rd_data = '0;
  logic             wb_vld;
  logic [TAG_W-1:0] wb_dest;
  logic [31:0]      wb_data;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;

  logic [7:0] mem [MEM_N];

  typedef struct {
    int               due;
    logic [TAG_W-1:0] tag;
    logic [31:0]      data;
    bit               care;
    string            req;
  } wb_item_t;

  typedef struct {
    int          due;
    logic [31:0] addr;
    string       req;
  } rd_item_t;

  wb_item_t wb_q[$];
  rd_item_t rd_q[$];

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk)
    if (mem_rd_en)
      mem_rd_data <= {mem[(mem_rd_addr + 32'd1) % MEM_N], mem[mem_rd_addr % MEM_N]};

  hw_ld16_unit #(.TAG_W(TAG_W)) dut_i (
    .clk(clk), .rst(rst),
    .iss_vld(iss_vld), .iss_base(iss_base), .iss_index(iss_index),
    .iss_guard(iss_guard), .iss_little(iss_little), .iss_dest(iss_dest),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .wb_vld(wb_vld), .wb_dest(wb_dest), .wb_data(wb_data)
  );

  function automatic logic [31:0] expect_val(input logic [31:0] a, input logic little);
    logic [7:0] b0, b1;
    b0 = mem[a % MEM_N];
    b1 = mem[(a + 32'd1) % MEM_N];
    return little ? {16'h0, b1, b0} : {16'h0, b0, b1};
  endfunction

  task automatic fail_line(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
    n_bad++;
    $display("FAIL %s %s: actual 0x%08h expected 0x%08h (cycle %0d)", req, what, act, exp, cyc);
  endtask

  task automatic issue(input logic [31:0] b, input logic [31:0] x, input logic [31:0] g,
                       input logic little, input logic [TAG_W-1:0] tag, input string req);
    logic [31:0] ea;
    bit          win;
    wb_item_t    w;
    rd_item_t    r;
    @(negedge clk);
    iss_vld = 1'b1; iss_base = b; iss_index = x; iss_guard = g;
    iss_little = little; iss_dest = tag;
    ea  = b + x;
    win = (ea >= 32'h0001_0000) && (ea < 32'h0001_1000);
    if (g[0]) begin
      w.due = cyc + 3; w.tag = tag; w.req = req;
      w.care = !ea[0];
      w.data = win ? 32'h0 : expect_val(ea, little);
      wb_q.push_back(w);
      if (!win) begin
        r.due = cyc + 1; r.addr = ea; r.req = req;
        rd_q.push_back(r);
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      iss_vld = 1'b0;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (rd_q.size() > 0 && rd_q[0].due < cyc) begin
        n_cmp++; fail_line(rd_q[0].req, "missing read", 32'h0, rd_q[0].addr);
        void'(rd_q.pop_front());
      end
      if (mem_rd_en) begin
        n_cmp++;
        if (rd_q.size() == 0) fail_line("R6", "unexpected read", mem_rd_addr, 32'h0);
        else begin
          rd_item_t r;
          r = rd_q.pop_front();
          if (r.due != cyc) fail_line(r.req, "read cycle", cyc, r.due);
          else if (mem_rd_addr != r.addr) fail_line(r.req, "read addr", mem_rd_addr, r.addr);
        end
      end
      if (wb_q.size() > 0 && wb_q[0].due < cyc) begin
        n_cmp++; fail_line(wb_q[0].req, "missing writeback", 32'h0, wb_q[0].data);
        void'(wb_q.pop_front());
      end
      if (wb_vld) begin
        n_cmp++;
        if (wb_q.size() == 0) fail_line("R6", "unexpected writeback", wb_data, 32'h0);
        else begin
          wb_item_t w;
          w = wb_q.pop_front();
          if (w.due != cyc) fail_line("R7", "writeback cycle", cyc, w.due);
          else if (wb_dest != w.tag) fail_line("R7", "tag", 32'(wb_dest), 32'(w.tag));
          else if (w.care && wb_data != w.data) fail_line(w.req, "data", wb_data, w.data);
          else if (wb_data[31:16] != 16'h0) fail_line("R5", "upper half", wb_data, 32'h0);
        end
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < MEM_N; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 5));
    mem[12'hD00] = 8'h84; mem[12'hD01] = 8'h33;
    mem[12'hD02] = 8'h22; mem[12'hD03] = 8'h11;

    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    n_cmp++;
    if (mem_rd_en !== 1'b0 || wb_vld !== 1'b0)
      fail_line("R1", "reset outputs", {mem_rd_en, wb_vld}, 32'h0);
    idle(3);
    n_cmp++;
    if (mem_rd_en !== 1'b0 || wb_vld !== 1'b0)
      fail_line("R1", "idle outputs", {mem_rd_en, wb_vld}, 32'h0);

    issue(32'hD00, 32'h2, 32'h1, 1'b0, 5'd1, "R3");          // 0x2211
    idle(5);
    issue(32'hD04, 32'hFFFF_FFFC, 32'h0, 1'b0, 5'd2, "R6");  // dropped
    idle(5);
    issue(32'hD04, 32'hFFFF_FFFC, 32'h1, 1'b0, 5'd3, "R3");  // 0x8433
    idle(5);
    issue(32'hD04, 32'hFFFF_FFFC, 32'h1, 1'b1, 5'd4, "R4");  // 0x3384
    idle(5);
    issue(32'hD00, 32'h0, 32'hFFFF_FFFE, 1'b1, 5'd5, "R6");  // dropped
    issue(32'hD02, 32'h0, 32'h3, 1'b1, 5'd6, "R6");          // 0x1122
    idle(5);
    issue(32'hFFFF_FFF0, 32'h20, 32'h1, 1'b0, 5'd7, "R2");   // wraps to 0x10
    idle(5);
    issue(32'hD01, 32'hFFFF_FFFC, 32'h1, 1'b0, 5'd8, "R9");  // odd, no fault
    idle(5);
    issue(32'h0001_0000, 32'h10, 32'h1, 1'b0, 5'd9, "R10");  // MMIO window
    idle(5);
    // R8: back-to-back mixed stream
    for (int k = 0; k < 24; k++)
      issue(32'(k * 66), 32'(k * 4 + 2), 32'((k % 5 == 3) ? 0 : 1),
            1'(k % 2), 5'(k), "R8");
    idle(8);
    n_cmp++;
    if (wb_q.size() != 0 || rd_q.size() != 0)
      fail_line("R7", "leftover items", wb_q.size(), 32'h0);
    finish_run();
  end

endmodule